// File: doc/BRIEF.md
# Indexed NVRAM Access Port with Lockable Windows

This block is the front end of a byte-wide non-volatile storage array that also holds the clock and watchdog registers as plain bytes. Software reaches the array indirectly through a four-byte I/O window. Two byte ports load the low and high halves of a 16-bit index register. A third port moves data to or from the byte the index selects. The fourth offset is a spare. After every data write the index returns to zero, so each new access sequence starts from a known place.

A second, direct path lets a bus master read or write one, two or four bytes in a single access. Multi-byte transfers are big-endian: the most significant byte sits at the lowest address. Both paths pass through the same guard. The guard rejects any address beyond the array. It also rejects two fixed 16-byte windows, each hidden while its lock bit is set. A pulse on the lock-toggle input flips one lock bit. Rejected reads return all-ones bytes and rejected writes are dropped.

Top module: `nvram_index_port`

## Requirements
- R1: A write to I/O offset 0 loads bits 7:0 of the index register and a write to offset 1 loads bits 15:8; the other half keeps its value.
- R2: A write to I/O offset 3 stores `io_wdata` at the indexed byte (when the guard allows it), and the index register then reads as 0x0000, whether or not the byte was stored.
- R3: A read of I/O offset 3 places the indexed byte on `io_rdata` at the clock edge of the request; reads leave the index register unchanged.
- R4: While lock bit 0 is set, bytes 0x20–0x2F are hidden; while lock bit 1 is set, bytes 0x30–0x3F are hidden. Hidden bytes read as 0xFF and writes to them are dropped, on both the I/O and the direct path.
- R5: A `lock_tgl` pulse inverts the lock bit chosen by `lock_idx`. An access in the same cycle still sees the old lock value, and bits that are not selected keep their value.
- R6: Addresses at or above DEPTH (512 by default), including those reached by a multi-byte transfer crossing the top of the array, read as 0xFF and writes to them are dropped.
- R7: Direct transfers use `mem_size` 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. Byte k of the transfer (k = 0 at `mem_addr`) is the k-th most significant byte of the used part of `mem_wdata`/`mem_rdata`. Read results are right-aligned and zero-extended, and `mem_rdata` updates at the edge of the read request.
- R8: Reads of I/O offsets 0, 1 and 2 return 0xFF. A write to offset 2 changes neither the index register nor the array.
- R9: Reset clears the index register to 0x0000, clears both lock bits, sets `io_rdata` to 0xFF and `mem_rdata` to zero.
- R10: In a multi-byte direct transfer each byte is guarded on its own. Allowed bytes are read or written normally, and hidden or out-of-range bytes read as 0xFF or are dropped.
- R11: When an I/O data write and a direct write hit the same byte in one cycle, the I/O value is the one stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | I/O window access strobe, one cycle per access |
| io_we | input | 1 | 1 = I/O write, 0 = I/O read |
| io_off | input | 2 | I/O offset: 0 index low, 1 index high, 2 spare, 3 data |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte, registered |
| lock_tgl | input | 1 | Pulse that flips one lock bit |
| lock_idx | input | 1 | Lock bit selected by the toggle |
| mem_sel | input | 1 | Direct access strobe |
| mem_we | input | 1 | 1 = direct write, 0 = direct read |
| mem_size | input | 2 | Transfer size code |
| mem_addr | input | 16 | Address of the first (most significant) byte |
| mem_wdata | input | 32 | Direct write data, right-aligned |
| mem_rdata | output | 32 | Direct read data, right-aligned, registered |

## Verification
A corrupted index half shows up at the next data-port read. It appears one edge later as a byte taken from the wrong location, or as 0xFF when the stray index leaves the array. A lock bit stuck high or flipped twice turns a byte in its window into 0xFF on the next read, or stops a write from landing, which the following read-back exposes. A missed index clear after a data write sends the next data access to the old location, so a read straight after the write returns the wrong byte.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

  typedef enum logic [1:0] {
    PORT_ADDR_LO = 2'd0,
    PORT_ADDR_HI = 2'd1,
    PORT_SPARE   = 2'd2,
    PORT_DATA    = 2'd3
  } port_sel_e;

  typedef enum logic [1:0] {
    XFER_BYTE     = 2'd0,
    XFER_HALF     = 2'd1,
    XFER_WORD     = 2'd2,
    XFER_WORD_ALT = 2'd3
  } xfer_size_e;

  localparam int LANES = 4;

  typedef logic [LANES-1:0][7:0] lane_bytes_t;

  // number of bytes moved by a direct transfer of the given size code
  function automatic int lane_count(logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // byte carried by lane k; lane 0 is the most significant used byte
  function automatic logic [7:0] lane_slice(logic [31:0] d, logic [1:0] sz, int lane);
    int n;
    n = lane_count(sz);
    if (lane >= n) return 8'h00;
    return d[8*(n-1-lane) +: 8];
  endfunction

  // reassemble lanes into a right-aligned, zero-extended word
  function automatic logic [31:0] lane_merge(lane_bytes_t b, logic [1:0] sz);
    logic [31:0] r;
    int n;
    r = '0;
    n = lane_count(sz);
    for (int k = 0; k < LANES; k++) begin
      if (k < n) r[8*(n-1-k) +: 8] = b[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/nvp_addr_reg.sv
module nvp_addr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          clr,
  input  logic [7:0]    din,
  output logic [AW-1:0] addr
);
  localparam int HIW = AW - 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (clr) begin
      addr <= '0;
    end else begin
      if (ld_lo) addr[7:0]    <= din;
      if (ld_hi) addr[AW-1:8] <= HIW'(din);
    end
  end

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo && !ld_hi && !clr) |=> (addr[7:0] == $past(din)) && (addr[AW-1:8] == $past(addr[AW-1:8]))); // R1
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !ld_lo && !clr) |=> (addr[7:0] == $past(addr[7:0]))); // R1
  AST_CLEAR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0)); // R2

endmodule

// File: rtl/nvp_lock_bits.sv
module nvp_lock_bits #(
  parameter int NLOCK = 2,
  localparam int IW = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgl,
  input  logic [IW-1:0]    idx,
  output logic [NLOCK-1:0] lock
);
  logic [NLOCK-1:0] flip;

  for (genvar g = 0; g < NLOCK; g++) begin : g_flip
    assign flip[g] = tgl && (idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock <= '0;
    else        lock <= lock ^ flip;
  end

  AST_TOGGLE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl && (int'(idx) < NLOCK)) |=> ($countones(lock ^ $past(lock)) == 1)); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tgl |=> $stable(lock)); // R5

endmodule

// File: rtl/nvp_guard.sv
module nvp_guard #(
  parameter int                     AW     = 16,
  parameter int                     DEPTH  = 512,
  parameter int                     NLOCK  = 2,
  parameter int                     SPAN   = 16,
  parameter logic [NLOCK*AW-1:0]    BASES  = {16'h0030, 16'h0020}
) (
  input  logic [AW:0]      addr,
  input  logic [NLOCK-1:0] lock,
  output logic             ok
);
  logic [NLOCK-1:0] hit;
  logic             in_range;

  for (genvar g = 0; g < NLOCK; g++) begin : g_win
    localparam logic [AW:0] WLO = {1'b0, BASES[g*AW +: AW]};
    localparam logic [AW:0] WHI = WLO + (AW+1)'(SPAN);
    assign hit[g] = lock[g] && (addr >= WLO) && (addr < WHI);
  end

  assign in_range = addr < (AW+1)'(DEPTH);
  assign ok       = in_range && !(|hit);

endmodule

// File: rtl/nvp_store.sv
module nvp_store #(
  parameter int DEPTH = 512,
  parameter int NPORT = 5,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic [NPORT-1:0]           we,
  input  logic [NPORT-1:0][IW-1:0]   idx,
  input  logic [NPORT-1:0][7:0]      wdata,
  output logic [NPORT-1:0][7:0]      rdata
);
  logic [7:0] cells [DEPTH];

  // later ports override earlier ones on the same cell
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (we[p]) cells[idx[p]] <= wdata[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) rdata[p] = cells[idx[p]];
  end

endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
  import nvp_pkg::*;
#(
  parameter int              DEPTH      = 512,
  parameter int              AW         = 16,
  parameter int              SPAN       = 16,
  parameter logic [2*AW-1:0] LOCK_BASES = {16'h0030, 16'h0020}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_sel,
  input  logic          io_we,
  input  logic [1:0]    io_off,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          lock_tgl,
  input  logic          lock_idx,
  input  logic          mem_sel,
  input  logic          mem_we,
  input  logic [1:0]    mem_size,
  input  logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_wdata,
  output logic [31:0]   mem_rdata
);
  localparam int NLOCK   = 2;
  localparam int NPORT   = LANES + 1;
  localparam int IO_PORT = LANES;
  localparam int IW      = $clog2(DEPTH);

  // decoded I/O events
  port_sel_e poff;
  logic io_rd_req, io_wr_req;
  logic ld_lo, ld_hi, data_wr, data_rd;
  logic mem_rd_req, mem_wr_req;

  assign poff       = port_sel_e'(io_off);
  assign io_rd_req  = io_sel && !io_we;
  assign io_wr_req  = io_sel && io_we;
  assign ld_lo      = io_wr_req && (poff == PORT_ADDR_LO);
  assign ld_hi      = io_wr_req && (poff == PORT_ADDR_HI);
  assign data_wr    = io_wr_req && (poff == PORT_DATA);
  assign data_rd    = io_rd_req && (poff == PORT_DATA);
  assign mem_rd_req = mem_sel && !mem_we;
  assign mem_wr_req = mem_sel && mem_we;

  logic [AW-1:0]    cur_addr;
  logic [NLOCK-1:0] lock;

  nvp_addr_reg #(.AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .clr   (data_wr),
    .din   (io_wdata),
    .addr  (cur_addr)
  );

  nvp_lock_bits #(.NLOCK(NLOCK)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .tgl   (lock_tgl),
    .idx   (lock_idx),
    .lock  (lock)
  );

  // per-lane address, guard and store port
  logic [NPORT-1:0][AW:0]   lane_addr;
  logic [NPORT-1:0]         lane_ok;
  logic [NPORT-1:0]         lane_we;
  logic [NPORT-1:0][IW-1:0] lane_idx;
  logic [NPORT-1:0][7:0]    lane_wdata;
  logic [NPORT-1:0][7:0]    lane_rdata;
  lane_bytes_t              shown;

  for (genvar k = 0; k < NPORT; k++) begin : g_lane
    if (k < LANES) begin : g_mem
      logic used;
      assign used          = k < lane_count(mem_size);
      assign lane_addr[k]  = {1'b0, mem_addr} + (AW+1)'(k);
      assign lane_we[k]    = mem_wr_req && used && lane_ok[k];
      assign lane_wdata[k] = lane_slice(mem_wdata, mem_size, k);
      assign shown[k]      = lane_ok[k] ? lane_rdata[k] : 8'hFF;
    end else begin : g_io
      assign lane_addr[k]  = {1'b0, cur_addr};
      assign lane_we[k]    = data_wr && lane_ok[k];
      assign lane_wdata[k] = io_wdata;
    end

    assign lane_idx[k] = lane_addr[k][IW-1:0];

    nvp_guard #(
      .AW    (AW),
      .DEPTH (DEPTH),
      .NLOCK (NLOCK),
      .SPAN  (SPAN),
      .BASES (LOCK_BASES)
    ) u_guard (
      .addr (lane_addr[k]),
      .lock (lock),
      .ok   (lane_ok[k])
    );
  end

  nvp_store #(.DEPTH(DEPTH), .NPORT(NPORT)) u_store (
    .clk   (clk),
    .we    (lane_we),
    .idx   (lane_idx),
    .wdata (lane_wdata),
    .rdata (lane_rdata)
  );

  // read returns
  logic [7:0] io_next;
  assign io_next = (data_rd && lane_ok[IO_PORT]) ? lane_rdata[IO_PORT] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata  <= 8'hFF;
      mem_rdata <= '0;
    end else begin
      if (io_rd_req)  io_rdata  <= io_next;
      if (mem_rd_req) mem_rdata <= lane_merge(shown, mem_size);
    end
  end

  // checks
  logic in_win0, in_win1;
  assign in_win0 = (cur_addr >= LOCK_BASES[AW-1:0]) &&
                   (cur_addr <  LOCK_BASES[AW-1:0] + AW'(SPAN));
  assign in_win1 = (cur_addr >= LOCK_BASES[2*AW-1:AW]) &&
                   (cur_addr <  LOCK_BASES[2*AW-1:AW] + AW'(SPAN));

  AST_LOCK0_HIDES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && lock[0] && in_win0) |=> (io_rdata == 8'hFF)); // R4
  AST_LOCK1_HIDES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && lock[1] && in_win1) |=> (io_rdata == 8'hFF)); // R4
  AST_RANGE_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && ({1'b0, cur_addr} >= (AW+1)'(DEPTH))) |=> (io_rdata == 8'hFF)); // R6
  AST_SPARE_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_req && (poff != PORT_DATA)) |=> (io_rdata == 8'hFF)); // R8
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && (mem_size == XFER_BYTE)) |=> (mem_rdata[31:8] == '0)); // R7
  AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && (mem_size == XFER_HALF)) |=> (mem_rdata[31:16] == '0)); // R7

endmodule

// File: tb/test_nvram_index_port.sv
`timescale 1ns/1ps
module test_nvram_index_port;

  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_sel = 0, io_we = 0, lock_tgl = 0, lock_idx = 0;
  logic [1:0]  io_off = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        mem_sel = 0, mem_we = 0;
  logic [1:0]  mem_size = 0;
  logic [15:0] mem_addr = 0;
  logic [31:0] mem_wdata = 0;
  logic [31:0] mem_rdata;

  always #10 clk = ~clk;

  nvram_index_port i_nvram_index_port (
    .clk(clk), .rst_n(rst_n),
    .io_sel(io_sel), .io_we(io_we), .io_off(io_off), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .lock_tgl(lock_tgl), .lock_idx(lock_idx),
    .mem_sel(mem_sel), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side picture of the block
  bit [7:0]  model [DEPTH];
  bit [1:0]  mlock = 0;
  bit [15:0] maddr = 0;

  typedef struct {
    bit          is_mem;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  function automatic bit m_ok(int a);
    if (a >= DEPTH) return 0;
    if (mlock[0] && a >= 32 && a < 48) return 0;
    if (mlock[1] && a >= 48 && a < 64) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] m_rd(int a);
    return m_ok(a) ? model[a] : 8'hFF;
  endfunction

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: results of reads issued at the previous edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, it.is_mem ? mem_rdata : {24'h0, io_rdata}, it.exp);
    end
  end

  task automatic idle();
    @(negedge clk);
    io_sel = 0; io_we = 0; mem_sel = 0; mem_we = 0; lock_tgl = 0;
  endtask

  task automatic io_op(bit we, logic [1:0] off, logic [7:0] d, bit flip, bit fidx, string tag);
    sb_item_t it;
    logic [7:0] e;
    @(negedge clk);
    e = (off == 2'd3) ? m_rd(int'(maddr)) : 8'hFF;
    io_sel = 1; io_we = we; io_off = off; io_wdata = d;
    mem_sel = 0; mem_we = 0; lock_tgl = flip; lock_idx = fidx;
    @(posedge clk);
    if (!we) begin
      it.is_mem = 0; it.exp = {24'h0, e}; it.tag = tag;
      sb_q.push_back(it);
    end else begin
      case (off)
        2'd0: maddr[7:0]  = d;
        2'd1: maddr[15:8] = d;
        2'd3: begin
          if (m_ok(int'(maddr))) model[maddr] = d;
          maddr = 0;
        end
        default: ;
      endcase
    end
    if (flip) mlock[fidx] = ~mlock[fidx];
  endtask

  task automatic io_wr(logic [1:0] off, logic [7:0] d);
    io_op(1, off, d, 0, 0, "");
  endtask

  task automatic io_rd(logic [1:0] off, string tag);
    io_op(0, off, 8'h00, 0, 0, tag);
  endtask

  task automatic io_rd_flip(bit fidx, string tag);
    io_op(0, 2'd3, 8'h00, 1, fidx, tag);
  endtask

  task automatic mem_op(bit we, logic [1:0] sz, logic [15:0] a, logic [31:0] d, string tag);
    sb_item_t it;
    logic [31:0] e;
    int n;
    n = nbytes(sz);
    @(negedge clk);
    e = 0;
    for (int k = 0; k < n; k++) e = (e << 8) | {24'h0, m_rd(int'(a) + k)};
    io_sel = 0; lock_tgl = 0;
    mem_sel = 1; mem_we = we; mem_size = sz; mem_addr = a; mem_wdata = d;
    @(posedge clk);
    if (!we) begin
      it.is_mem = 1; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
    end else begin
      for (int k = 0; k < n; k++) begin
        if (m_ok(int'(a) + k)) model[int'(a) + k] = 8'((d >> (8 * (n - 1 - k))) & 32'hFF);
      end
    end
  endtask

  task automatic lock_flip(bit idx);
    @(negedge clk);
    io_sel = 0; mem_sel = 0; lock_tgl = 1; lock_idx = idx;
    @(posedge clk);
    mlock[idx] = ~mlock[idx];
  endtask

  // I/O data write and direct byte write to the same byte in one cycle
  task automatic collide(logic [7:0] iov, logic [7:0] memv);
    @(negedge clk);
    io_sel = 1; io_we = 1; io_off = 2'd3; io_wdata = iov;
    mem_sel = 1; mem_we = 1; mem_size = 2'd0; mem_addr = maddr; mem_wdata = {24'h0, memv};
    lock_tgl = 0;
    @(posedge clk);
    if (m_ok(int'(maddr))) model[maddr] = memv;
    if (m_ok(int'(maddr))) model[maddr] = iov;
    maddr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 io_rdata in reset", {24'h0, io_rdata}, 32'h0000_00FF);
    chk("R9 mem_rdata in reset", mem_rdata, 32'h0);
    rst_n = 1;

    // fill the whole array through the direct path (locks clear after reset)
    for (int a = 0; a < DEPTH; a += 4)
      mem_op(1, 2'd2, 16'(a), {8'(a), 8'(a + 1), 8'(a + 2), 8'(a + 3)} ^ 32'h5AC3_17E9, "");
    mem_op(0, 2'd0, 16'h0025, 0, "R9 locks clear after reset");

    // index cleared by reset: first data write lands at byte 0
    io_wr(2'd3, 8'hA5);
    mem_op(0, 2'd0, 16'h0000, 0, "R9 index zero after reset");

    // R1 index halves
    io_wr(2'd1, 8'h01);
    io_wr(2'd0, 8'h23);
    io_rd(2'd3, "R1 index 0x123");
    io_wr(2'd0, 8'h44);
    io_rd(2'd3, "R1 low write keeps high half");
    io_wr(2'd1, 8'h00);
    io_rd(2'd3, "R1 high write keeps low half");
    io_rd(2'd3, "R3 read leaves index unchanged");

    // R2 data write then auto-clear
    io_wr(2'd0, 8'h10);
    io_wr(2'd3, 8'h3C);
    mem_op(0, 2'd0, 16'h0010, 0, "R2 byte stored at index");
    io_rd(2'd3, "R2 index cleared after write");

    // R8 spare offset and address-port reads
    io_wr(2'd0, 8'h44);
    io_wr(2'd2, 8'hEE);
    io_rd(2'd2, "R8 spare read");
    io_rd(2'd0, "R8 low index port read");
    io_rd(2'd1, "R8 high index port read");
    io_rd(2'd3, "R8 spare write ignored");

    // R4 lock windows
    lock_flip(0);
    io_wr(2'd0, 8'h28);
    io_rd(2'd3, "R4 lock0 hides read");
    io_wr(2'd3, 8'hC3);
    mem_op(0, 2'd2, 16'h002C, 0, "R4 lock0 hides direct read");
    mem_op(0, 2'd2, 16'h001E, 0, "R10 lock0 lower edge");
    mem_op(0, 2'd2, 16'h002E, 0, "R10 lock0 upper edge");
    lock_flip(0);
    io_wr(2'd0, 8'h28);
    io_rd(2'd3, "R4 locked write dropped");
    lock_flip(1);
    mem_op(0, 2'd2, 16'h002E, 0, "R10 lock1 lower edge");
    mem_op(0, 2'd2, 16'h003E, 0, "R10 lock1 upper edge");
    mem_op(1, 2'd1, 16'h003E, 32'h0000_1234, "");
    mem_op(1, 2'd2, 16'h002E, 32'hDEAD_BEEF, "");
    lock_flip(1);
    mem_op(0, 2'd1, 16'h003E, 0, "R4 locked direct write dropped");
    mem_op(0, 2'd2, 16'h002E, 0, "R10 partial direct write");

    // R5 toggle timing
    io_wr(2'd0, 8'h22);
    io_rd_flip(0, "R5 same-cycle access sees old lock");
    io_rd(2'd3, "R5 toggle effective next cycle");
    io_rd_flip(0, "R5 same-cycle access sees old lock set");
    io_rd(2'd3, "R5 second toggle unlocks");
    lock_flip(1);
    io_rd(2'd3, "R5 other lock bit unaffected");
    lock_flip(1);

    // R6 out of range
    io_wr(2'd1, 8'h02);
    io_wr(2'd0, 8'h00);
    io_rd(2'd3, "R6 index past array");
    io_wr(2'd3, 8'h66);
    mem_op(0, 2'd0, 16'h0000, 0, "R6 dropped write not aliased");
    mem_op(0, 2'd2, 16'h01FE, 0, "R6 transfer crossing top");
    mem_op(0, 2'd2, 16'hFFFE, 0, "R6 transfer at address wrap");
    mem_op(1, 2'd2, 16'h01FE, 32'h0A0B_0C0D, "");
    mem_op(0, 2'd1, 16'h01FE, 0, "R10 top bytes of crossing write");

    // R7 big-endian sizes
    mem_op(1, 2'd1, 16'h0050, 32'hFFFF_BEEF, "");
    mem_op(0, 2'd0, 16'h0050, 0, "R7 half MSB at low address");
    mem_op(0, 2'd0, 16'h0051, 0, "R7 half LSB at high address");
    mem_op(1, 2'd2, 16'h0060, 32'h1122_3344, "");
    mem_op(0, 2'd2, 16'h0060, 0, "R7 word read");
    mem_op(0, 2'd1, 16'h0062, 0, "R7 half read zero-extended");
    mem_op(1, 2'd3, 16'h0064, 32'h99AA_BBCC, "");
    mem_op(0, 2'd3, 16'h0064, 0, "R7 size code 3 as word");
    mem_op(1, 2'd0, 16'h0067, 32'hFFFF_FF77, "");
    mem_op(0, 2'd2, 16'h0064, 0, "R7 byte write touches one byte");
    io_wr(2'd0, 8'h61);
    io_rd(2'd3, "R7 direct write seen through I/O");

    // R11 same-byte collision
    io_wr(2'd0, 8'h70);
    collide(8'h99, 8'h55);
    mem_op(0, 2'd0, 16'h0070, 0, "R11 I/O write wins collision");
    io_rd(2'd3, "R11 index cleared after collision");

    idle();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule